// File: doc/BRIEF.md
# Counting Tracking ADC Controller

This block is the digital half of a counting (servo) analog-to-digital converter. It drives an external N-bit DAC from a saturating up/down code register and reads one comparator bit. The comparator bit is high while the DAC output is below the analog input. The comparator bit passes through a two-stage synchronizer before use. The code only moves once the synchronized comparator reflects the latest code: one step every `SYNC_STAGES+1` clocks, which is 3 clocks at the defaults.

There are two run modes, chosen by `track_i`.

- **Single-shot mode** (`track_i` low): a `start_i` pulse clears the code and ramps it upward. End-of-conversion is raised at the first decision that finds the comparator low, or when the code reaches full scale. The result then stays frozen until the next start.
- **Tracking mode** (`track_i` high): the code is not cleared. At every decision it steps toward the input, up or down. The data output drops the LSB, which hides the 1-LSB dither whenever that dither stays inside an even/odd code pair.

The controller has four states:

- `ST_IDLE`: reached from reset or on leaving tracking.
- `ST_CONVERT`: the ramp in progress.
- `ST_DONE`: the result is held and EOC is high.
- `ST_TRACK`: free-running tracking.

The transitions are as follows:

- `track_i` high moves any state to `ST_TRACK`.
- `start_i` with `track_i` low moves any state to `ST_CONVERT`.
- `ST_CONVERT` moves to `ST_DONE` on a decision with the comparator low or the code at full scale.
- `ST_TRACK` moves to `ST_IDLE` when `track_i` falls.
- Otherwise the state holds.

Top module: `servo_adc_ctrl`

## Requirements
- R1: After reset `dac_code_o`, `data_o` and `eoc_o` are all zero.
- R2: A `start_i` pulse with `track_i` low clears `dac_code_o` to zero and drops `eoc_o` on the next clock. This also applies during a conversion in progress, which then restarts.
- R3: In single-shot mode the code advances by exactly one every 3 clocks while the synchronized comparator is high. The comparator value used is the one sampled two clocks earlier. Apart from a clear, the code never changes by more than one per clock.
- R4: A single-shot conversion ends with `eoc_o` high and a result that is 0 to +1 LSB above the input, that is, the smallest code not below the input.
- R5: While `eoc_o` is high and neither `start_i` nor `track_i` is asserted, `eoc_o` stays high and `data_o` stays unchanged.
- R6: In tracking mode the code is kept on entry. Every 3 clocks it steps up by one if the synchronized comparator is high, or down by one if it is low, so a steady input gives a 1-LSB dither.
- R7: In tracking mode `eoc_o` is low and `data_o` equals the code with bit 0 forced to zero.
- R8: The code saturates at all-ones and at zero and never wraps around. A single-shot input at or above full scale ends with result all-ones.
- R9: When `track_i` falls, `eoc_o` stays low and the code holds. `data_o` then shows the full code, including bit 0, until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a single-shot conversion |
| track_i | input | 1 | High selects tracking mode |
| cmp_i | input | 1 | Comparator: high while the DAC output is below the input |
| dac_code_o | output | N | Code driving the DAC |
| data_o | output | N | Conversion result; bit 0 is zero in tracking mode |
| eoc_o | output | 1 | End of a single-shot conversion |

## Verification
The bench drives an ideal DAC and comparator, with the input expressed in quarter-LSB steps. A design that decides on a stale synchronizer value would overshoot by two codes, and the per-clock model comparison catches this.

The corner cases probed are:

- **Inputs exactly on a code boundary, zero, and above full scale.** An off-by-one end condition, or a counter that wraps, would give a result outside the 0 to +1 LSB bound, or a code of zero after full scale.
- **A restart mid-ramp.** A design that ignores the second start would keep its partial code.
- **Tracking entered from a held result, and driven into both rails.** A design that clears the code on entry, or leaks the LSB, would show a reset code or a flickering data word.

// File: rtl/servo_adc_pkg.sv
package servo_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_DONE    = 2'd2,
        ST_TRACK   = 2'd3
    } adc_state_e;

endpackage

// File: rtl/servo_adc_sync.sv
module servo_adc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/servo_adc_pacer.sv
module servo_adc_pacer #(
    parameter int GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/servo_adc_counter.sv
module servo_adc_counter #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [WIDTH-1:0] code_o,
    output logic             at_max_o
);
    localparam logic [WIDTH-1:0] TOP = '1;

    logic at_min;

    assign at_max_o = (code_o == TOP);
    assign at_min   = (code_o == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
        end else if (clr_i) begin
            code_o <= '0;
        end else if (step_i) begin
            if (up_i && !at_max_o) begin
                code_o <= code_o + 1'b1;
            end else if (!up_i && !at_min) begin
                code_o <= code_o - 1'b1;
            end
        end
    end
endmodule

// File: rtl/servo_adc_ctrl.sv
module servo_adc_ctrl
    import servo_adc_pkg::*;
#(
    parameter int N           = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         track_i,
    input  logic         cmp_i,
    output logic [N-1:0] dac_code_o,
    output logic [N-1:0] data_o,
    output logic         eoc_o
);
    localparam int STEP_GAP = SYNC_STAGES + 1;

    adc_state_e state_q, state_d;
    logic       cmp_s;
    logic       tick;
    logic       at_max;
    logic       clr;
    logic       pace_restart;
    logic       pace_run;
    logic       step;
    logic       step_up;

    servo_adc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    servo_adc_pacer #(.GAP(STEP_GAP)) pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (pace_restart),
        .run_i     (pace_run),
        .tick_o    (tick)
    );

    servo_adc_counter #(.WIDTH(N)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .step_i   (step),
        .up_i     (step_up),
        .code_o   (dac_code_o),
        .at_max_o (at_max)
    );

    // Control decode for counter and pacer
    always_comb begin
        clr          = start_i && !track_i;
        pace_restart = (track_i && (state_q != ST_TRACK)) || clr;
        pace_run     = ((state_q == ST_CONVERT) && !track_i && !start_i)
                    || ((state_q == ST_TRACK) && track_i);
        step_up      = (state_q == ST_TRACK) ? cmp_s : 1'b1;
        step         = tick && ((state_q == ST_TRACK) || (cmp_s && !at_max));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (track_i) begin
            state_d = ST_TRACK;
        end else if (start_i) begin
            state_d = ST_CONVERT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_CONVERT: if (tick && !(cmp_s && !at_max)) state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                ST_TRACK:   state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        eoc_o  = 1'b0;
        data_o = dac_code_o;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CONVERT: ;
            ST_DONE:    eoc_o = 1'b1;
            ST_TRACK:   data_o = {dac_code_o[N-1:1], 1'b0};
            default:    ;
        endcase
    end
endmodule

// File: rtl/servo_adc_ctrl_chk.sv
module servo_adc_ctrl_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         track_i,
    input logic [N-1:0] dac_code_o,
    input logic [N-1:0] data_o,
    input logic         eoc_o
);
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !track_i) |=> (dac_code_o == '0) && !eoc_o); // R2

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !track_i) |=>
            (dac_code_o == $past(dac_code_o))
            || ({1'b0, dac_code_o} == {1'b0, $past(dac_code_o)} + 1'b1)
            || ({1'b0, $past(dac_code_o)} == {1'b0, dac_code_o} + 1'b1)); // R3

    AST_EOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && !start_i && !track_i) |=> eoc_o && $stable(data_o)); // R5

    AST_TRACK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        track_i |=> !eoc_o && !data_o[0]); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((dac_code_o == '1) && !(start_i && !track_i)) |=> (dac_code_o != '0)); // R8
endmodule

bind servo_adc_ctrl servo_adc_ctrl_chk #(.N(N)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .track_i    (track_i),
    .dac_code_o (dac_code_o),
    .data_o     (data_o),
    .eoc_o      (eoc_o)
);

// File: tb/servo_adc_ctrl_tb_top.sv
module servo_adc_ctrl_tb_top;
    localparam int N            = 10;
    localparam int MAXC         = (1 << N) - 1;
    localparam int SETTLE       = 3;
    localparam int CLK_PERIOD_NS = 10;
    localparam int WATCHDOG     = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         track_i = 1'b0;
    logic         cmp_i;
    logic [N-1:0] dac_code_o;
    logic [N-1:0] data_o;
    logic         eoc_o;

    int vin4 = 0;   // analog input in quarter-LSB units
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    // ideal DAC plus comparator
    assign cmp_i = (int'(dac_code_o) * 4 < vin4);

    servo_adc_ctrl #(.N(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .track_i    (track_i),
        .cmp_i      (cmp_i),
        .dac_code_o (dac_code_o),
        .data_o     (data_o),
        .eoc_o      (eoc_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 ramp, 2 done, 3 tracking
    int m_code = 0, m_mode = 0, m_pace = 0, m_s1 = 0, m_s2 = 0;

    always @(posedge clk) begin : ref_model
        int oc;
        int os2;
        if (!rst_n) begin
            m_code = 0; m_mode = 0; m_pace = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            oc  = m_code;
            os2 = m_s2;
            m_s2 = m_s1;
            m_s1 = (oc * 4 < vin4) ? 1 : 0;
            if (track_i) begin
                if (m_mode != 3) begin
                    m_mode = 3; m_pace = 0;
                end else if (m_pace == SETTLE - 1) begin
                    m_pace = 0;
                    if (os2 != 0) begin
                        if (m_code < MAXC) m_code++;
                    end else if (m_code > 0) begin
                        m_code--;
                    end
                end else begin
                    m_pace++;
                end
            end else if (start_i) begin
                m_mode = 1; m_code = 0; m_pace = 0;
            end else if (m_mode == 3) begin
                m_mode = 0;
            end else if (m_mode == 1) begin
                if (m_pace == SETTLE - 1) begin
                    m_pace = 0;
                    if (os2 != 0 && m_code < MAXC) m_code++;
                    else m_mode = 2;
                end else begin
                    m_pace++;
                end
            end
        end
    end

    // per-clock comparison against the reference (R3 ramp, R6 tracking)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_data;
            exp_data = (m_mode == 3) ? (m_code & ~1) : m_code;
            chk(int'(dac_code_o) == m_code, (m_mode == 3) ? "R6 code" : "R3 code",
                int'(dac_code_o), m_code);
            chk(eoc_o == (m_mode == 2), (m_mode == 3) ? "R6 eoc" : "R3 eoc",
                int'(eoc_o), (m_mode == 2) ? 1 : 0);
            chk(int'(data_o) == exp_data, (m_mode == 3) ? "R7 data" : "R3 data",
                int'(data_o), exp_data);
        end
    end

    task automatic convert(input int v, output int res);
        int guard;
        @(negedge clk);
        vin4 = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(dac_code_o == '0, "R2 clear on start", int'(dac_code_o), 0);
        guard = 0;
        while (!eoc_o && guard < SETTLE * (MAXC + 4)) begin
            @(negedge clk);
            guard++;
        end
        chk(eoc_o == 1'b1, "R4 eoc reached", int'(eoc_o), 1);
        res = int'(data_o);
    endtask

    task automatic check_result(input int v, input int res, input string tag);
        int exp;
        exp = (v + 3) / 4;
        if (exp > MAXC) exp = MAXC;
        chk(res == exp, tag, res, exp);
        if (v <= MAXC * 4) chk((res * 4 - v >= 0) && (res * 4 - v < 4), "R4 error bound", res * 4 - v, 0);
    endtask

    initial begin : stim
        int res;
        int prev;
        int moves;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(dac_code_o == '0, "R1 code", int'(dac_code_o), 0);
        chk(data_o == '0, "R1 data", int'(data_o), 0);
        chk(eoc_o == 1'b0, "R1 eoc", int'(eoc_o), 0);

        convert(401, res);
        check_result(401, res, "R4 mid-code input");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(eoc_o && int'(data_o) == res, "R5 result held", int'(data_o), res);
        end

        convert(148, res);
        check_result(148, res, "R4 boundary input");
        convert(0, res);
        check_result(0, res, "R4 zero input");
        convert(4 * MAXC + 3, res);
        check_result(4 * MAXC + 3, res, "R8 full scale result");

        // restart mid-ramp
        @(negedge clk);
        vin4 = 2000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        chk(dac_code_o != '0, "R2 ramp under way", int'(dac_code_o), 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(dac_code_o == '0 && !eoc_o, "R2 restart clears", int'(dac_code_o), 0);
        convert(2000, res);
        check_result(2000, res, "R4 after restart");

        // tracking keeps the held code
        vin4 = 4 * 500 + 2;
        track_i = 1'b1;
        @(negedge clk);
        chk(int'(dac_code_o) == 500, "R6 code kept on entry", int'(dac_code_o), 500);
        repeat (10) @(negedge clk);
        moves = 0;
        prev = int'(dac_code_o);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (int'(dac_code_o) != prev) moves++;
            prev = int'(dac_code_o);
            chk(dac_code_o == 10'd500 || dac_code_o == 10'd501, "R6 dither range", int'(dac_code_o), 500);
            chk(int'(data_o) == 500 && !eoc_o, "R7 masked output", int'(data_o), 500);
        end
        chk(moves >= 10, "R6 dither present", moves, 20);

        vin4 = 4 * 300 + 2;
        repeat (SETTLE * 200 + 30) @(negedge clk);
        chk(dac_code_o == 10'd300 || dac_code_o == 10'd301, "R6 tracks downward", int'(dac_code_o), 300);

        vin4 = 5000;
        repeat (SETTLE * (MAXC - 300) + 30) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(int'(dac_code_o) == MAXC, "R8 hold at top", int'(dac_code_o), MAXC);
        end
        vin4 = 0;
        repeat (SETTLE * MAXC + 30) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(dac_code_o == '0, "R8 hold at zero", int'(dac_code_o), 0);
        end

        // leaving tracking
        vin4 = 4 * 201 + 2;
        repeat (SETTLE * 210 + 30) @(negedge clk);
        track_i = 1'b0;
        @(negedge clk);
        prev = int'(dac_code_o);
        chk(prev == 201 || prev == 202, "R9 code held on exit", prev, 201);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(int'(dac_code_o) == prev && int'(data_o) == prev && !eoc_o,
                "R9 idle after tracking", int'(data_o), prev);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule